// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on a CPU bus with 16-bit addresses and 8-bit data, in front of a cartridge ROM, a battery-backed RAM and a generic memory port. A CPU write anywhere in the lower half of the address space never reaches the ROM. The block decodes it by address bits [15:13] into one of four control writes: RAM enable, low ROM bank field, shared two-bit field, and banking mode. From the state these writes leave, the block builds the physical ROM address for reads of the switchable window 0x4000–0x7FFF. It also builds the physical RAM address for accesses to 0xA000–0xBFFF, and it blocks RAM strobes while the RAM is disabled.

The banking mode is a two-state machine. `MAP_SIMPLE` is the reset state. In it the shared field supplies the top two bits of a 7-bit ROM bank, and RAM always uses bank 0. `MAP_ADVANCED` hands the shared field over to the RAM bank, and the ROM bank keeps only its five low bits. There are two transitions. `ENTER_ADV` is a mode write with data bit 0 set, and it is taken only when the cartridge has the four-bank RAM. `LEAVE_ADV` is a mode write with data bit 0 clear.

Cartridge configuration is sampled while reset is asserted. It consists of the ROM bank count as a base-2 logarithm and a RAM size code: 0 means no RAM, 1 means 2 KB, 2 means 8 KB and 3 means 32 KB in four banks. Read data returns one cycle after the read strobe. All other accesses go unchanged to the pass-through port.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the block is in `MAP_SIMPLE`, the ROM bank is 1, the shared field is 0, the RAM bank is 0 and RAM is disabled.
- R2: A write to 0x0000–0x1FFF enables RAM when data[3:0] is 0xA and disables it for any other value. When the RAM size code is 0, such writes have no effect.
- R3: A write to 0x2000–0x3FFF forms a candidate bank from data[4:0]. In `MAP_SIMPLE` the shared field is placed above it as bits [6:5]. In `MAP_ADVANCED` bits [6:5] are zero.
- R4: In `MAP_SIMPLE`, a write to 0x4000–0x5FFF stores data[1:0] in the shared field. It also recomputes the ROM bank at once from that field and the current bank's bits [4:0].
- R5: Every recomputed ROM bank whose bits [4:0] are zero is incremented by one. The result is then ANDed with (ROM bank count − 1).
- R6: In `MAP_ADVANCED`, a write to 0x4000–0x5FFF sets the RAM bank to data[1:0] and leaves the ROM bank unchanged. In `MAP_SIMPLE`, RAM accesses use bank 0.
- R7: A write to 0x6000–0x7FFF moves to the mode given by data[0]. A request for `MAP_ADVANCED` is refused unless the RAM size code is 3.
- R8: A read of 0x4000–0x7FFF raises `rom_rd` with `rom_addr` = {bank, addr[13:0]}. The ROM byte appears on `cpu_rdata` in the following cycle.
- R9: While RAM is enabled, accesses to 0xA000–0xBFFF strobe the RAM with `ram_addr` = {RAM bank in use, addr[12:0]}. A read returns the RAM byte one cycle later.
- R10: While RAM is disabled, reads of 0xA000–0xBFFF return 0xFF and writes are discarded. Neither `ram_rd` nor `ram_wr` is raised.
- R11: `acc_err` is high during an access to the RAM window in two cases: RAM is disabled, or the size code is 1 and addr[12:11] is nonzero. When RAM is enabled, the access still goes ahead at the unbanked offset.
- R12: These accesses appear unchanged on the pass-through port: reads outside 0x4000–0x7FFF and 0xA000–0xBFFF, and writes outside 0x0000–0x7FFF and 0xA000–0xBFFF. A pass-through read returns `pass_rdata` one cycle later.
- R13: Configuration inputs are captured only while `rst_n` is low. Changes after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cfg_rom_log2 | input | 3 | log2 of the ROM bank count |
| cfg_ram_code | input | 2 | RAM size code (0 none, 1 2 KB, 2 8 KB, 3 32 KB) |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_rd | output | 1 | ROM read strobe |
| rom_rdata | input | 8 | ROM data (synchronous) |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM data (synchronous) |
| pass_addr | output | 16 | Pass-through address |
| pass_wdata | output | 8 | Pass-through write data |
| pass_rd | output | 1 | Pass-through read strobe |
| pass_wr | output | 1 | Pass-through write strobe |
| pass_rdata | input | 8 | Pass-through data (synchronous) |
| acc_err | output | 1 | High during a disabled or out-of-size RAM-window access |

## Verification
The low-bank and shared-field writes are driven with several value patterns. Zero low bits with each of the shared values tell the increment apart from plain concatenation. A 16-bank configuration separates masking from fixing, since a value of 0x10 escapes the increment but masks to bank 0. The same 0x4000 write is issued under each mode to show that it lands in the ROM bank in one mode and in the RAM bank in the other. Separate resets with RAM codes 0, 1, 2 and 3 distinguish the enable, refusal and 2 KB error paths. The ROM model returns bank XOR offset and the RAM model returns stored bytes, so read-back data proves the mapping from end to end.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    // Region code equals address bits [15:13]
    typedef enum logic [2:0] {
        RG_ENA    = 3'd0,
        RG_BANKLO = 3'd1,
        RG_SHARED = 3'd2,
        RG_MODE   = 3'd3,
        RG_VID    = 3'd4,
        RG_XRAM   = 3'd5,
        RG_WRK    = 3'd6,
        RG_HIGH   = 3'd7
    } region_e;

    typedef enum logic {
        MAP_SIMPLE   = 1'b0,
        MAP_ADVANCED = 1'b1
    } map_mode_e;

    typedef enum logic [1:0] {
        SRC_PASS = 2'd0,
        SRC_ROM  = 2'd1,
        SRC_RAM  = 2'd2,
        SRC_OPEN = 2'd3
    } rsrc_e;

    localparam logic [1:0] RAMCODE_NONE = 2'd0;
    localparam logic [1:0] RAMCODE_2K   = 2'd1;
    localparam logic [1:0] RAMCODE_32K  = 2'd3;

endpackage

// File: rtl/cbc_region_decode.sv
module cbc_region_decode
    import cbc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              in_ctl,
    output logic              in_romsw,
    output logic              in_xram
);
    always_comb begin
        region   = region_e'(addr[ADDR_W-1 -: 3]);
        in_ctl   = ~addr[ADDR_W-1];
        in_romsw = (addr[ADDR_W-1 -: 2] == 2'b01);
        in_xram  = (region == RG_XRAM);
    end
endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
    import cbc_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int HI_W       = 2,
    parameter int RAM_BANK_W = 2,
    localparam int LO_W      = ROM_BANK_W - HI_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_wr,
    input  region_e               region,
    input  logic [LO_W-1:0]       wdata,
    input  logic [ROM_BANK_W-1:0] rom_mask,
    input  logic [RAM_BANK_W-1:0] ram_mask,
    input  logic                  adv_allowed,
    input  logic                  ram_present,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank_eff,
    output logic                  ram_en,
    output logic                  mode_adv
);
    map_mode_e             state_q, state_d;
    logic [HI_W-1:0]       shared_q;
    logic [RAM_BANK_W-1:0] ram_bank_q;
    logic [ROM_BANK_W-1:0] rom_bank_q;
    logic                  ram_en_q;
    logic                  mode_wr;

    function automatic logic [ROM_BANK_W-1:0] fix_bank(
        input logic [ROM_BANK_W-1:0] raw,
        input logic [ROM_BANK_W-1:0] msk
    );
        logic [ROM_BANK_W-1:0] b;
        b = raw;
        if (raw[LO_W-1:0] == '0) b = raw + 1'b1;
        return b & msk;
    endfunction

    assign mode_wr = ctl_wr && (region == RG_MODE);

    // Next-state logic: ENTER_ADV / LEAVE_ADV
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_SIMPLE:   if (mode_wr && wdata[0] && adv_allowed) state_d = MAP_ADVANCED;
            MAP_ADVANCED: if (mode_wr && !wdata[0])               state_d = MAP_SIMPLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_SIMPLE;
        else        state_q <= state_d;
    end

    // Bank and enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_bank_q <= ROM_BANK_W'(1);
            shared_q   <= '0;
            ram_bank_q <= '0;
            ram_en_q   <= 1'b0;
        end else if (ctl_wr) begin
            case (region)
                RG_ENA: if (ram_present) ram_en_q <= (wdata[3:0] == 4'hA);
                RG_BANKLO: begin
                    if (state_q == MAP_SIMPLE)
                        rom_bank_q <= fix_bank({shared_q, wdata}, rom_mask);
                    else
                        rom_bank_q <= fix_bank({{HI_W{1'b0}}, wdata}, rom_mask);
                end
                RG_SHARED: begin
                    if (state_q == MAP_SIMPLE) begin
                        shared_q   <= wdata[HI_W-1:0];
                        rom_bank_q <= fix_bank({wdata[HI_W-1:0], rom_bank_q[LO_W-1:0]}, rom_mask);
                    end else begin
                        ram_bank_q <= wdata[RAM_BANK_W-1:0] & ram_mask;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs derived from state
    always_comb begin
        mode_adv     = (state_q == MAP_ADVANCED);
        ram_bank_eff = mode_adv ? ram_bank_q : '0;
        rom_bank     = rom_bank_q;
        ram_en       = ram_en_q;
    end
endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
    import cbc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ROM_BANK_W = 7,
    parameter int ROM_OFS_W  = 14,
    parameter int RAM_BANK_W = 2,
    parameter int RAM_OFS_W  = 13,
    localparam int ROM_AW    = ROM_BANK_W + ROM_OFS_W,
    localparam int RAM_AW    = RAM_BANK_W + RAM_OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic                  in_ctl,
    input  logic                  in_romsw,
    input  logic                  in_xram,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    input  logic [RAM_BANK_W-1:0] ram_bank_eff,
    input  logic                  ram_en,
    input  logic                  ram_small,
    input  logic [DATA_W-1:0]     rom_rdata,
    input  logic [DATA_W-1:0]     ram_rdata,
    input  logic [DATA_W-1:0]     pass_rdata,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic                  rom_rd,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic [DATA_W-1:0]     ram_wdata,
    output logic                  ram_rd,
    output logic                  ram_wr,
    output logic [ADDR_W-1:0]     pass_addr,
    output logic [DATA_W-1:0]     pass_wdata,
    output logic                  pass_rd,
    output logic                  pass_wr,
    output logic                  acc_err,
    output logic [DATA_W-1:0]     cpu_rdata
);
    rsrc_e src_q;
    logic  beyond_small;

    always_comb begin
        rom_rd       = bus_rd && in_romsw;
        rom_addr     = {rom_bank, bus_addr[ROM_OFS_W-1:0]};
        ram_addr     = {ram_bank_eff, bus_addr[RAM_OFS_W-1:0]};
        ram_wdata    = bus_wdata;
        ram_rd       = bus_rd && in_xram && ram_en;
        ram_wr       = bus_wr && in_xram && ram_en;
        pass_addr    = bus_addr;
        pass_wdata   = bus_wdata;
        pass_rd      = bus_rd && !in_romsw && !in_xram;
        pass_wr      = bus_wr && !in_ctl && !in_xram;
        beyond_small = ram_small && (bus_addr[RAM_OFS_W-1:11] != '0);
        acc_err      = (bus_rd || bus_wr) && in_xram && (!ram_en || beyond_small);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= SRC_PASS;
        else if (bus_rd) begin
            if (in_romsw)     src_q <= SRC_ROM;
            else if (in_xram) src_q <= ram_en ? SRC_RAM : SRC_OPEN;
            else              src_q <= SRC_PASS;
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_ROM:  cpu_rdata = rom_rdata;
            SRC_RAM:  cpu_rdata = ram_rdata;
            SRC_OPEN: cpu_rdata = '1;
            default:  cpu_rdata = pass_rdata;
        endcase
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ROM_BANK_W = 7,
    parameter int ROM_OFS_W  = 14,
    parameter int RAM_BANK_W = 2,
    parameter int RAM_OFS_W  = 13,
    localparam int SZ_W      = $clog2(ROM_BANK_W + 1),
    localparam int ROM_AW    = ROM_BANK_W + ROM_OFS_W,
    localparam int RAM_AW    = RAM_BANK_W + RAM_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SZ_W-1:0]   cfg_rom_log2,
    input  logic [1:0]        cfg_ram_code,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_rd,
    output logic              ram_wr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [DATA_W-1:0] pass_wdata,
    output logic              pass_rd,
    output logic              pass_wr,
    input  logic [DATA_W-1:0] pass_rdata,
    output logic              acc_err
);
    localparam int HI_W = 2;
    localparam int LO_W = ROM_BANK_W - HI_W;

    logic [SZ_W-1:0]       rom_log2_q;
    logic [1:0]            ram_code_q;
    logic [ROM_BANK_W:0]   one_sh;
    logic [ROM_BANK_W-1:0] rom_mask;
    logic [RAM_BANK_W-1:0] ram_mask;
    logic                  adv_allowed, ram_present, ram_small;
    region_e               region;
    logic                  in_ctl, in_romsw, in_xram;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank_eff;
    logic                  ram_en, mode_adv;

    // Configuration follows the inputs only while reset is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_log2_q <= cfg_rom_log2;
            ram_code_q <= cfg_ram_code;
        end
    end

    always_comb begin
        one_sh      = (ROM_BANK_W+1)'(1) << rom_log2_q;
        rom_mask    = ROM_BANK_W'(one_sh - 1'b1);
        adv_allowed = (ram_code_q == RAMCODE_32K);
        ram_mask    = {RAM_BANK_W{adv_allowed}};
        ram_present = (ram_code_q != RAMCODE_NONE);
        ram_small   = (ram_code_q == RAMCODE_2K);
    end

    cbc_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .region(region), .in_ctl(in_ctl),
        .in_romsw(in_romsw), .in_xram(in_xram)
    );

    cbc_bank_regs #(.ROM_BANK_W(ROM_BANK_W), .HI_W(HI_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(bus_wr && in_ctl), .region(region),
        .wdata(bus_wdata[LO_W-1:0]), .rom_mask(rom_mask), .ram_mask(ram_mask),
        .adv_allowed(adv_allowed), .ram_present(ram_present),
        .rom_bank(rom_bank), .ram_bank_eff(ram_bank_eff), .ram_en(ram_en),
        .mode_adv(mode_adv)
    );

    cbc_addr_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .ROM_OFS_W(ROM_OFS_W),
        .RAM_BANK_W(RAM_BANK_W), .RAM_OFS_W(RAM_OFS_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .in_ctl(in_ctl), .in_romsw(in_romsw),
        .in_xram(in_xram), .rom_bank(rom_bank), .ram_bank_eff(ram_bank_eff),
        .ram_en(ram_en), .ram_small(ram_small), .rom_rdata(rom_rdata),
        .ram_rdata(ram_rdata), .pass_rdata(pass_rdata), .rom_addr(rom_addr),
        .rom_rd(rom_rd), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rd(ram_rd),
        .ram_wr(ram_wr), .pass_addr(pass_addr), .pass_wdata(pass_wdata),
        .pass_rd(pass_rd), .pass_wr(pass_wr), .acc_err(acc_err), .cpu_rdata(cpu_rdata)
    );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ROM_BANK_W = 7,
    parameter int ROM_OFS_W  = 14,
    parameter int RAM_BANK_W = 2,
    parameter int RAM_OFS_W  = 13,
    localparam int ROM_AW    = ROM_BANK_W + ROM_OFS_W,
    localparam int RAM_AW    = RAM_BANK_W + RAM_OFS_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic [ROM_AW-1:0]     rom_addr,
    input logic                  rom_rd,
    input logic [RAM_AW-1:0]     ram_addr,
    input logic [DATA_W-1:0]     ram_wdata,
    input logic                  ram_rd,
    input logic                  ram_wr,
    input logic [ADDR_W-1:0]     pass_addr,
    input logic [DATA_W-1:0]     pass_wdata,
    input logic                  pass_wr,
    input logic                  acc_err,
    input logic                  ram_en,
    input logic                  mode_adv,
    input logic [1:0]            ram_code_q,
    input logic [ROM_BANK_W-1:0] rom_mask
);
    logic in_xram;
    assign in_xram = (bus_addr[ADDR_W-1 -: 3] == 3'b101);

    // R8
    rom_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> rom_addr[ROM_OFS_W-1:0] == bus_addr[ROM_OFS_W-1:0]);

    // R5
    rom_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> (rom_addr[ROM_AW-1:ROM_OFS_W] & ~rom_mask) == '0);

    // R7
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_adv) |-> ram_code_q == 2'd3);

    // R6
    simple_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd || ram_wr) && !mode_adv |-> ram_addr[RAM_AW-1:RAM_OFS_W] == '0);

    // R9
    ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> bus_wr && in_xram && ram_wdata == bus_wdata);

    // R10
    ram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && in_xram && !ram_en |-> !ram_rd && !ram_wr && acc_err);

    // R12
    pass_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_wr |-> pass_addr == bus_addr && pass_wdata == bus_wdata && !ram_wr);
endmodule

bind cart_bank_ctrl cbc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .ROM_OFS_W(ROM_OFS_W),
    .RAM_BANK_W(RAM_BANK_W), .RAM_OFS_W(RAM_OFS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .rom_addr(rom_addr), .rom_rd(rom_rd),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .pass_addr(pass_addr), .pass_wdata(pass_wdata), .pass_wr(pass_wr),
    .acc_err(acc_err), .ram_en(ram_en), .mode_adv(mode_adv),
    .ram_code_q(ram_code_q), .rom_mask(rom_mask)
);

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_rom_log2 = 3'd7;
    logic [1:0]  cfg_ram_code = 2'd3;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  cpu_rdata, rom_rdata, ram_rdata, pass_rdata;
    logic [20:0] rom_addr;
    logic        rom_rd;
    logic [14:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_rd, ram_wr;
    logic [15:0] pass_addr;
    logic [7:0]  pass_wdata;
    logic        pass_rd, pass_wr, acc_err;

    int n_chk = 0, n_fail = 0;

    // snapshots of combinational outputs during an access
    logic [20:0] s_rom_addr;
    logic        s_rom_rd, s_ram_rd, s_ram_wr, s_err, s_pass_rd, s_pass_wr;
    logic [14:0] s_ram_addr;
    logic [15:0] s_pass_addr;
    logic [7:0]  s_pass_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_ctrl i_cart_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_rom_log2(cfg_rom_log2), .cfg_ram_code(cfg_ram_code),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .ram_rdata(ram_rdata), .pass_addr(pass_addr), .pass_wdata(pass_wdata),
        .pass_rd(pass_rd), .pass_wr(pass_wr), .pass_rdata(pass_rdata), .acc_err(acc_err)
    );

    // Memory models: ROM byte = bank XOR offset low byte; small RAM; pass = addr ^ 0x5A
    logic [7:0] ram_mem [128];
    function automatic logic [6:0] ram_idx(input logic [14:0] a);
        return {a[14:13], a[11], a[3:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) ram_mem[i] <= 8'hFF;
        end else begin
            if (ram_wr) ram_mem[ram_idx(ram_addr)] <= ram_wdata;
            if (ram_rd) ram_rdata <= ram_mem[ram_idx(ram_addr)];
        end
        if (rom_rd)  rom_rdata  <= {1'b0, rom_addr[20:14]} ^ rom_addr[7:0];
        if (pass_rd) pass_rdata <= pass_addr[7:0] ^ 8'h5A;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] lg, input logic [1:0] code);
        @(negedge clk);
        rst_n = 1'b0; cfg_rom_log2 = lg; cfg_ram_code = code;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        s_err = acc_err; s_ram_wr = ram_wr; s_ram_addr = ram_addr;
        s_pass_wr = pass_wr; s_pass_addr = pass_addr; s_pass_wdata = pass_wdata;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] rd);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        s_rom_addr = rom_addr; s_rom_rd = rom_rd; s_ram_addr = ram_addr;
        s_ram_rd = ram_rd; s_err = acc_err; s_pass_rd = pass_rd; s_pass_addr = pass_addr;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        rd = cpu_rdata;
    endtask

    task automatic t_reset_state;
        logic [7:0] d;
        do_reset(3'd7, 2'd3);
        bus_read(16'h4000, d);
        chk("R1 rom bank 1", s_rom_addr, 21'h04000);
        chk("R8 rom data", d, 8'h01);
        bus_read(16'hA000, d);
        chk("R1 ram disabled data", d, 8'hFF);
        chk("R11 err disabled", s_err, 1'b1);
        chk("R10 no ram_rd", s_ram_rd, 1'b0);
        bus_write(16'h4000, 8'h01);   // simple mode: shared field -> ROM bits
        bus_read(16'h4000, d);
        chk("R1 simple mode", s_rom_addr, 21'h84000);
    endtask

    task automatic t_ram_enable;
        logic [7:0] d;
        do_reset(3'd7, 2'd3);
        bus_write(16'h0000, 8'h3A);
        bus_write(16'hA005, 8'h77);
        chk("R9 ram_wr", s_ram_wr, 1'b1);
        chk("R9 ram_addr", s_ram_addr, 15'h0005);
        chk("R11 no err", s_err, 1'b0);
        bus_read(16'hA005, d);
        chk("R2 enabled read", d, 8'h77);
        bus_write(16'h1000, 8'h0B);
        bus_read(16'hA005, d);
        chk("R2 disabled read", d, 8'hFF);
        bus_write(16'hA005, 8'h11);
        chk("R10 write dropped strobe", s_ram_wr, 1'b0);
        bus_write(16'h0000, 8'hFA);
        bus_read(16'hA005, d);
        chk("R10 write dropped data", d, 8'h77);
    endtask

    task automatic t_rom_fields;
        logic [7:0] d;
        do_reset(3'd7, 2'd3);
        bus_write(16'h2000, 8'h05);
        bus_read(16'h4123, d);
        chk("R3 low bank", s_rom_addr, 21'h14123);
        chk("R8 data", d, 8'h26);
        bus_write(16'h2000, 8'hE7);
        bus_read(16'h7FFF, d);
        chk("R3 low 5 bits only", s_rom_addr, 21'h1FFFF);
        chk("R8 data top", d, 8'hF8);
        bus_write(16'h4000, 8'h02);
        bus_read(16'h4000, d);
        chk("R4 shared recompute", s_rom_addr, 21'h11C000);
        bus_write(16'h2000, 8'h00);
        bus_read(16'h4000, d);
        chk("R5 fix 0x40", s_rom_addr, 21'h104000);
        bus_write(16'h4000, 8'h01);
        bus_write(16'h2000, 8'h20);
        bus_read(16'h4000, d);
        chk("R5 fix 0x20", s_rom_addr, 21'h84000);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        do_reset(3'd4, 2'd3);
        bus_write(16'h2000, 8'h1F);
        bus_read(16'h4000, d);
        chk("R5 mask 0x1F", s_rom_addr, 21'h3C000);
        bus_write(16'h2000, 8'h10);
        bus_read(16'h4ABC, d);
        chk("R5 mask to bank 0", s_rom_addr, 21'h00ABC);
        chk("R8 bank0 data", d, 8'hBC);
        bus_write(16'h4000, 8'h03);
        bus_read(16'h4000, d);
        chk("R5 fix then mask", s_rom_addr, 21'h04000);
    endtask

    task automatic t_advanced;
        logic [7:0] d;
        do_reset(3'd7, 2'd3);
        bus_write(16'h4000, 8'h01);
        bus_write(16'h6000, 8'h01);
        bus_write(16'h2000, 8'h03);
        bus_read(16'h4000, d);
        chk("R3 advanced ignores shared", s_rom_addr, 21'h0C000);
        bus_write(16'h4000, 8'h02);
        bus_read(16'h4000, d);
        chk("R6 rom unchanged", s_rom_addr, 21'h0C000);
        bus_write(16'h0000, 8'h0A);
        bus_write(16'hA010, 8'h99);
        chk("R6 ram bank 2 addr", s_ram_addr, 15'h4010);
        bus_read(16'hA010, d);
        chk("R9 banked read", d, 8'h99);
        bus_write(16'h6000, 8'h00);
        bus_read(16'hA010, d);
        chk("R6 simple uses bank 0", s_ram_addr, 15'h0010);
        chk("R6 bank 0 data", d, 8'hFF);
    endtask

    task automatic t_refused;
        logic [7:0] d;
        do_reset(3'd7, 2'd2);
        bus_write(16'h6000, 8'h01);
        bus_write(16'h4000, 8'h01);
        bus_read(16'h4000, d);
        chk("R7 mode refused", s_rom_addr, 21'h84000);
        do_reset(3'd7, 2'd0);
        bus_write(16'h0000, 8'h0A);
        bus_read(16'hA000, d);
        chk("R2 no ram data", d, 8'hFF);
        chk("R2 no ram err", s_err, 1'b1);
    endtask

    task automatic t_small_ram;
        logic [7:0] d;
        do_reset(3'd7, 2'd1);
        bus_write(16'h0000, 8'h0A);
        bus_write(16'hA800, 8'h42);
        chk("R11 err above 2K", s_err, 1'b1);
        chk("R11 write proceeds", s_ram_wr, 1'b1);
        chk("R11 unbanked addr", s_ram_addr, 15'h0800);
        bus_read(16'hA800, d);
        chk("R11 read back", d, 8'h42);
        bus_read(16'hA7FF, d);
        chk("R11 no err below", s_err, 1'b0);
    endtask

    task automatic t_pass;
        logic [7:0] d;
        do_reset(3'd7, 2'd3);
        bus_write(16'hC123, 8'h3C);
        chk("R12 pass_wr", s_pass_wr, 1'b1);
        chk("R12 pass addr", s_pass_addr, 16'hC123);
        chk("R12 pass data", s_pass_wdata, 8'h3C);
        bus_write(16'h2000, 8'h02);
        chk("R12 control not passed", s_pass_wr, 1'b0);
        bus_read(16'h0100, d);
        chk("R12 pass_rd", s_pass_rd, 1'b1);
        chk("R12 pass read data", d, 8'h5A);
        bus_read(16'h4000, d);
        chk("R12 rom not passed", s_pass_rd, 1'b0);
    endtask

    task automatic t_cfg_frozen;
        logic [7:0] d;
        do_reset(3'd7, 2'd3);
        cfg_rom_log2 = 3'd1; cfg_ram_code = 2'd0;
        bus_write(16'h0000, 8'h0A);
        bus_write(16'hA001, 8'h66);
        chk("R13 ram still present", s_ram_wr, 1'b1);
        bus_write(16'h2000, 8'h06);
        bus_read(16'h4000, d);
        chk("R13 rom mask kept", s_rom_addr, 21'h18000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ram_enable();
        t_rom_fields();
        t_mask();
        t_advanced();
        t_refused();
        t_small_ram();
        t_pass();
        t_cfg_frozen();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule